// File: doc/BRIEF.md
# Multiplexed Program-Fetch Bus Sequencer

This block runs the external program-memory read cycle for an 8-bit controller core whose low address byte and returned data share one port. The core raises a request with a 16-bit fetch address. The sequencer places the upper address byte on a dedicated port and the lower byte on the shared port. It then pulses an address-latch strobe so that external logic can capture the lower byte. After that it releases the shared port and pulls an active-low read strobe so that the memory can drive the opcode back.

All timing is counted in whole clock periods. The latch strobe is high for two clocks. The read strobe falls one clock after the latch strobe falls and stays low for three clocks. The returned byte is sampled two clocks after the read strobe falls. It is handed to the core, with a one-clock valid pulse, in the clock where the read strobe returns high. A request raised in the final clock of a cycle starts the next cycle with no idle clock in between, so a stream of fetches runs at one byte every six clocks. The sequencer changes state only on clock edges. If the clock is stopped at either level, every strobe and address holds.

Top module: `opfetch_seq`

## Requirements
- R1: Under synchronous active-high reset, and on the first clock after reset, the block shows `ale_o`=0, `psen_n_o`=1, `port_lo_oe_o`=0, `opcode_valid_o`=0 and `ready_o`=1.
- R2: A request sampled with `ready_o`=1 raises `ale_o` on that same edge. `ale_o` then stays high for exactly 2 clocks.
- R3: The shared port drives the low address byte (`port_lo_oe_o`=1, `port_lo_o`=`addr_i[7:0]` as captured at acceptance) from the clock where `ale_o` rises through the 1 clock that follows the fall of `ale_o`. That is 3 clocks in all.
- R4: `psen_n_o` falls exactly 1 clock after `ale_o` falls. It then stays low for exactly 3 clocks.
- R5: `port_lo_oe_o` is 0 whenever `psen_n_o` is 0 and whenever the block is idle.
- R6: `addr_hi_o` shows `addr_i[15:8]` from the clock where `ale_o` rises. It stays unchanged for the whole cycle and for any idle time after it, until the next accepted request.
- R7: `port_lo_i` is sampled only at the edge that ends the second low clock of `psen_n_o`. Values present on that port in the first or third low clock have no effect on `opcode_o`.
- R8: `opcode_o` takes the sampled byte and `opcode_valid_o` pulses high for exactly 1 clock. Both happen in the clock where `psen_n_o` returns high. `opcode_o` does not change at any other time.
- R9: `ready_o` is 1 when idle and in the last low clock of `psen_n_o`, and 0 otherwise. A request accepted in that last clock raises `ale_o` in the very next clock, giving a 6-clock fetch period.
- R10: A request held high while `ready_o`=0 is ignored. The running cycle keeps its timing, and `addr_hi_o` and `port_lo_o` keep the address accepted earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every timing is a whole number of its periods |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Fetch request from the core |
| addr_i | input | 16 | Fetch address, captured when the request is accepted |
| ready_o | output | 1 | A request sampled now is accepted |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program read strobe, active low |
| addr_hi_o | output | 8 | Upper address byte on the dedicated port |
| port_lo_o | output | 8 | Lower address byte for the shared port |
| port_lo_oe_o | output | 1 | Output enable of the shared port; 0 means high impedance |
| port_lo_i | input | 8 | Byte read back from the shared port |
| opcode_o | output | 8 | Last fetched opcode byte |
| opcode_valid_o | output | 1 | One-clock pulse marking a new opcode |

## Verification
The hardest situation to reach is a fetch that starts back-to-back with the previous one. Here a new request lands in the last read-strobe clock, while the old opcode is being handed out and the new latch strobe is rising in the same clock. The bench reaches it by raising the next request at the falling edge that follows the fifth cycle edge, and it chains three such fetches. A second hard case is proving that capture happens only at one edge. For this, the bench's memory model drives the wrong byte in the first and third read-strobe clocks and the right byte only in the second. The bench also holds a request high, with a different address, across a busy cycle to show that it is ignored.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  // Phase of one program fetch. The order of phases is fixed by the bus cycle.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LATCH = 2'd1,  // address-latch strobe high
    PH_HOLD  = 2'd2,  // strobe low, low address still driven
    PH_READ  = 2'd3   // read strobe low, shared port released
  } fetch_phase_t;

endpackage

// File: rtl/opfetch_ctl.sv
module opfetch_ctl
  import opfetch_pkg::*;
#(
  parameter int LATCH_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 3,
  parameter int SAMPLE_AT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic ready_o,
  output logic accept_o,
  output logic drive_nxt_o,
  output logic ale_o,
  output logic psen_n_o,
  output logic sample_o,
  output logic done_o
);

  localparam int CW = $clog2(LATCH_CYC + HOLD_CYC + READ_CYC + 1);
  localparam logic [CW-1:0] LIM_LATCH = CW'(LATCH_CYC - 1);
  localparam logic [CW-1:0] LIM_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LIM_READ  = CW'(READ_CYC - 1);
  localparam logic [CW-1:0] SMP_CNT   = CW'(SAMPLE_AT - 1);

  fetch_phase_t   phase_q, phase_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ale_q, psen_n_q;
  logic           last_read;

  assign last_read = (phase_q == PH_READ) && (cnt_q == LIM_READ);
  assign ready_o   = (phase_q == PH_IDLE) || last_read;
  assign accept_o  = req_i && ready_o;
  assign sample_o  = (phase_q == PH_READ) && (cnt_q == SMP_CNT);
  assign done_o    = last_read;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (accept_o) begin
          phase_d = PH_LATCH;
          cnt_d   = '0;
        end
      end
      PH_LATCH: begin
        if (cnt_q == LIM_LATCH) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == LIM_HOLD) begin
          phase_d = PH_READ;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_READ: begin
        if (cnt_q == LIM_READ) begin
          phase_d = accept_o ? PH_LATCH : PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign drive_nxt_o = (phase_d == PH_LATCH) || (phase_d == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      ale_q    <= 1'b0;
      psen_n_q <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      ale_q    <= (phase_d == PH_LATCH);
      psen_n_q <= (phase_d != PH_READ);
    end
  end

  assign ale_o    = ale_q;
  assign psen_n_o = psen_n_q;

  // Checker counters: lengths of the strobe pulses and of the gap between them.
  logic [CW-1:0] ale_run, low_run, since_ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_run   <= '0;
      low_run   <= '0;
      since_ale <= '0;
    end else begin
      ale_run   <= ale_o ? ((ale_run == '1) ? ale_run : ale_run + 1'b1) : '0;
      low_run   <= !psen_n_o ? ((low_run == '1) ? low_run : low_run + 1'b1) : '0;
      since_ale <= ale_o ? '0 : ((since_ale == '1) ? since_ale : since_ale + 1'b1);
    end
  end

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ale_o) |-> ale_run == CW'(LATCH_CYC));

  // R4
  psen_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n_o) |-> since_ale == CW'(HOLD_CYC));

  // R4
  psen_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(psen_n_o) |-> low_run == CW'(READ_CYC));

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ale_o || !psen_n_o) && ready_o |-> !psen_n_o);

endmodule

// File: rtl/opfetch_addr.sv
module opfetch_addr #(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              drive_nxt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-LO_W-1:0] addr_hi_o,
  output logic [LO_W-1:0]   port_lo_o,
  output logic              port_oe_o
);

  localparam int HI_W = ADDR_W - LO_W;

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (accept_i) begin
        hi_q <= addr_i[ADDR_W-1:LO_W];
        lo_q <= addr_i[LO_W-1:0];
      end
      oe_q <= drive_nxt_i;
    end
  end

  assign addr_hi_o = hi_q;
  assign port_lo_o = lo_q;
  assign port_oe_o = oe_q;

  // R6
  hi_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_hi_o) |-> $past(accept_i));

  // R3
  lo_stable_chk: assert property (@(posedge clk) disable iff (rst)
    port_oe_o && $past(port_oe_o) |-> $stable(port_lo_o));

endmodule

// File: rtl/opfetch_cap.sv
module opfetch_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] opcode_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] grab_q;
  logic [DATA_W-1:0] op_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      grab_q <= '0;
      op_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (sample_i) grab_q <= data_i;
      if (done_i)   op_q   <= grab_q;
      vld_q <= done_i;
    end
  end

  assign opcode_o = op_q;
  assign valid_o  = vld_q;

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8
  opcode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(opcode_o) |-> valid_o);

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LATCH_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 3,
  parameter int SAMPLE_AT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic                     ready_o,
  output logic                     ale_o,
  output logic                     psen_n_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        port_lo_o,
  output logic                     port_lo_oe_o,
  input  logic [DATA_W-1:0]        port_lo_i,
  output logic [DATA_W-1:0]        opcode_o,
  output logic                     opcode_valid_o
);

  logic accept, drive_nxt, sample, done;

  opfetch_ctl #(
    .LATCH_CYC(LATCH_CYC),
    .HOLD_CYC (HOLD_CYC),
    .READ_CYC (READ_CYC),
    .SAMPLE_AT(SAMPLE_AT)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .drive_nxt_o(drive_nxt),
    .ale_o      (ale_o),
    .psen_n_o   (psen_n_o),
    .sample_o   (sample),
    .done_o     (done)
  );

  opfetch_addr #(
    .ADDR_W(ADDR_W),
    .LO_W  (DATA_W)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .drive_nxt_i(drive_nxt),
    .addr_i     (addr_i),
    .addr_hi_o  (addr_hi_o),
    .port_lo_o  (port_lo_o),
    .port_oe_o  (port_lo_oe_o)
  );

  opfetch_cap #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .sample_i(sample),
    .done_i  (done),
    .data_i  (port_lo_i),
    .opcode_o(opcode_o),
    .valid_o (opcode_valid_o)
  );

  // R5
  port_release_chk: assert property (@(posedge clk) disable iff (rst)
    !psen_n_o |-> !port_lo_oe_o);

  // R8
  valid_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    opcode_valid_o |-> $rose(psen_n_o));

  // R2
  ale_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ale_o |-> port_lo_oe_o);

endmodule

// File: tb/sim_opfetch_seq.sv
module sim_opfetch_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        ready_o, ale_o, psen_n_o, port_lo_oe_o, opcode_valid_o;
  logic [7:0]  addr_hi_o, port_lo_o, opcode_o;
  logic [7:0]  port_lo_i = 8'hA5;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] q_addr[$];
  logic [7:0]  q_data[$];
  logic [7:0]  cur_data = '0;
  logic [7:0]  held = '0;
  int          lowc = 0;
  bit          prev_valid = 1'b0;

  always #10 clk = ~clk;

  opfetch_seq u0 (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_i),
    .addr_i        (addr_i),
    .ready_o       (ready_o),
    .ale_o         (ale_o),
    .psen_n_o      (psen_n_o),
    .addr_hi_o     (addr_hi_o),
    .port_lo_o     (port_lo_o),
    .port_lo_oe_o  (port_lo_oe_o),
    .port_lo_i     (port_lo_i),
    .opcode_o      (opcode_o),
    .opcode_valid_o(opcode_valid_o)
  );

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: right byte only in the second read-strobe clock (R7).
  always @(negedge clk) begin
    if (psen_n_o) begin
      lowc      = 0;
      port_lo_i = 8'hA5;
    end else begin
      lowc++;
      if (lowc == 1) begin
        held      = cur_data;
        port_lo_i = ~cur_data;
      end else if (lowc == 2) begin
        port_lo_i = held;
      end else begin
        port_lo_i = ~held;
      end
    end
  end

  // Monitor: pops expected opcodes as valid pulses appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (opcode_valid_o) begin
        chk_eq("R8 valid with psen high", psen_n_o, 1);
        chk_eq("R8 single-clock valid", prev_valid, 0);
        if (q_data.size() == 0) begin
          chk_eq("R8 unexpected valid", 1, 0);
        end else begin
          logic [7:0]  ed;
          logic [15:0] ea;
          ed = q_data.pop_front();
          ea = q_addr.pop_front();
          chk_eq($sformatf("R7 R8 opcode for addr %0h", ea), opcode_o, ed);
        end
      end
      prev_valid = opcode_valid_o;
    end
  end

  task automatic fetch(input logic [15:0] a, input logic [7:0] d, input bit hold);
    req_i    = 1'b1;
    addr_i   = a;
    cur_data = d;
    q_addr.push_back(a);
    q_data.push_back(d);
    chk_eq("R9 ready before accept", ready_o, 1);
    @(negedge clk);
    if (hold) addr_i = ~a;
    else      req_i  = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      chk_eq($sformatf("R2 ale clk%0d", k), ale_o, (k <= 2));
      chk_eq($sformatf("R4 psen_n clk%0d", k), psen_n_o, (k <= 3));
      chk_eq($sformatf("R3 R5 oe clk%0d", k), port_lo_oe_o, (k <= 3));
      if (k <= 3) chk_eq($sformatf("R3 R10 lo addr clk%0d", k), port_lo_o, a[7:0]);
      chk_eq($sformatf("R6 R10 hi addr clk%0d", k), addr_hi_o, a[15:8]);
      chk_eq($sformatf("R9 ready clk%0d", k), ready_o, (k == 6));
      if (hold && k == 5) req_i = 1'b0;
    end
  endtask

  task automatic idle(input int n, input logic [7:0] hi);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_eq("R5 idle ale", ale_o, 0);
      chk_eq("R5 idle psen_n", psen_n_o, 1);
      chk_eq("R5 idle oe", port_lo_oe_o, 0);
      chk_eq("R6 hi held idle", addr_hi_o, hi);
      chk_eq("R9 ready idle", ready_o, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 ale", ale_o, 0);
    chk_eq("R1 psen_n", psen_n_o, 1);
    chk_eq("R1 oe", port_lo_oe_o, 0);
    chk_eq("R1 valid", opcode_valid_o, 0);
    chk_eq("R1 ready", ready_o, 1);

    fetch(16'h1234, 8'h5A, 1'b0);
    idle(3, 8'h12);
    // R10: request held with another address while busy
    fetch(16'hABCD, 8'hC3, 1'b1);
    idle(2, 8'hAB);
    // R9: three chained fetches, no idle clock between them
    fetch(16'h0100, 8'h01, 1'b0);
    fetch(16'hFFFF, 8'hFF, 1'b0);
    fetch(16'h8000, 8'h80, 1'b0);
    idle(2, 8'h80);
    fetch(16'h00FE, 8'h00, 1'b0);
    idle(3, 8'h00);
    chk_eq("R8 all opcodes delivered", q_data.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule